// File: doc/BRIEF.md
# CPU Address Window Decoder with Remap

This block sits on a CPU's outgoing address path and decides which target an address belongs to. A parameterised set of windows is configured through a small register port. Each window has a base, a size mask, a low and a high remap value, and one bit in a shared disable mask. The address is compared against every window at once. The block returns a hit flag, the index of the winning window and a 64-bit outgoing address. Windows at or above a parameterised index are bridge windows, and their outgoing address is remapped.

A separate internal-register window has a fixed 64 KB size and only a movable base. It lets the CPU reach the chip's own registers, and it takes precedence over every programmable window. Decode is combinational from the address and the stored configuration. Configuration writes land on the clock edge.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window's disable bit is set (the mask reads back as all ones), so no window hits. Base, size and remap registers read 0, and the internal-register base reads REG_BASE_RST.
- R2: An enabled window i hits when addr[31:16] & ~size[i] equals base[i] & ~size[i]. Base and size are in 64 KB units, and size holds the window length in units minus one.
- R3: A window whose bit in the disable mask (kind 4, bit i) is 1 never hits, whatever its base and size.
- R4: When several enabled windows hit, the lowest index wins. When none hits, win_hit is 0, win_idx is 0 and out_addr is {32'h0, addr}.
- R5: A size write (kind 1) is stored only if the 16-bit value is a run of ones from bit 0 followed only by zeros, that is (v & (v+1)) == 0. Any other value is ignored and the register keeps its old value.
- R6: Reading kind 5 for window i returns 0 when the window is disabled. Otherwise it returns ({size[i], 16'hFFFF} + 1) truncated to 32 bits.
- R7: For a hit on a window with index >= REMAP_FIRST, out_addr is {remap_hi, (base & ~size) | (remap_lo & size), addr[15:0]}. For a hit on a lower window, out_addr is {32'h0, addr}.
- R8: The internal-register window hits when addr[31:16] equals bits [15:0] of its 20-bit base register (kind 6). While it hits, reg_hit is 1, win_hit is 0, win_idx is 0 and out_addr is {32'h0, addr}, even if a programmable window also matches.
- R9: A write appears in the decode and in read-back on the clock edge that samples cfg_we. Before that edge the outputs still reflect the old value. Kinds: 0 base[15:0], 1 size[15:0], 2 remap low[15:0], 3 remap high[31:0], 4 disable mask, 6 internal base[19:0]. Fields read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Register kind selector |
| cfg_idx | input | IW | Window index for per-window kinds |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read-back of the selected register |
| addr | input | 32 | CPU address to decode |
| win_hit | output | 1 | A programmable window matched |
| win_idx | output | IW | Index of the winning window |
| reg_hit | output | 1 | The internal-register window matched |
| out_addr | output | 64 | Translated outgoing address |

## Verification
On every cycle, assertions check four things: the internal-register hit and a window hit never occur together, a miss always gives index 0 with a pass-through address, the winning window is never disabled, and a stored size is always a legal mask. They also check that a mask write shows up on the next cycle. Priority among overlapping windows, the remap bit splice with the high word, the effective-size arithmetic including its wrap to 0, and the rejection of illegal sizes depend on particular register contents. Only the bench's directed scenarios, compared with its own model, show those.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int          NUM_WIN      = 8,
  parameter int          REMAP_FIRST  = 4,
  parameter logic [19:0] REG_BASE_RST = 20'h01400,
  localparam int         IW           = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_kind,
  input  logic [IW-1:0] cfg_idx,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [31:0]   addr,
  output logic          win_hit,
  output logic [IW-1:0] win_idx,
  output logic          reg_hit,
  output logic [63:0]   out_addr
);

  localparam logic [2:0] K_BASE = 3'd0, K_SIZE = 3'd1, K_RLO = 3'd2, K_RHI = 3'd3,
                         K_DIS  = 3'd4, K_EFF  = 3'd5, K_REG = 3'd6;

  logic [15:0]        base_q [NUM_WIN];
  logic [15:0]        size_q [NUM_WIN];
  logic [15:0]        rlo_q  [NUM_WIN];
  logic [31:0]        rhi_q  [NUM_WIN];
  logic [NUM_WIN-1:0] dis_q;
  logic [19:0]        rbase_q;
  logic [NUM_WIN-1:0] hv;

  wire [15:0] wlo       = cfg_wdata[15:0];
  wire        size_ok   = (wlo & (wlo + 16'd1)) == 16'd0;
  wire [15:0] page      = addr[31:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
        rlo_q[i]  <= '0;
        rhi_q[i]  <= '0;
      end
      dis_q   <= '1;
      rbase_q <= REG_BASE_RST;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (cfg_idx == IW'(i)) begin
          if (cfg_kind == K_BASE)           base_q[i] <= wlo;
          if (cfg_kind == K_SIZE && size_ok) size_q[i] <= wlo;
          if (cfg_kind == K_RLO)            rlo_q[i]  <= wlo;
          if (cfg_kind == K_RHI)            rhi_q[i]  <= cfg_wdata;
        end
      end
      if (cfg_kind == K_DIS) dis_q   <= cfg_wdata[NUM_WIN-1:0];
      if (cfg_kind == K_REG) rbase_q <= cfg_wdata[19:0];
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
    assign hv[g] = ~dis_q[g] & ((page & ~size_q[g]) == (base_q[g] & ~size_q[g]));
  end

  logic          any;
  logic [IW-1:0] sel;
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hv[i]) begin
        any = 1'b1;
        sel = IW'(i);
      end
    end
  end

  assign reg_hit = page == rbase_q[15:0];
  assign win_hit = any & ~reg_hit;
  assign win_idx = win_hit ? sel : '0;

  wire [15:0] spliced = (base_q[sel] & ~size_q[sel]) | (rlo_q[sel] & size_q[sel]);
  wire        remap   = win_hit && (32'(sel) >= REMAP_FIRST);
  assign out_addr = remap ? {rhi_q[sel], spliced, addr[15:0]} : {32'h0, addr};

  wire in_range = 32'(cfg_idx) < NUM_WIN;
  always_comb begin
    cfg_rdata = '0;
    case (cfg_kind)
      K_BASE: if (in_range) cfg_rdata = {16'h0, base_q[cfg_idx]};
      K_SIZE: if (in_range) cfg_rdata = {16'h0, size_q[cfg_idx]};
      K_RLO:  if (in_range) cfg_rdata = {16'h0, rlo_q[cfg_idx]};
      K_RHI:  if (in_range) cfg_rdata = rhi_q[cfg_idx];
      K_DIS:  cfg_rdata = 32'(dis_q);
      K_EFF:  if (in_range && !dis_q[cfg_idx]) cfg_rdata = {size_q[cfg_idx], 16'hFFFF} + 32'd1;
      K_REG:  cfg_rdata = {12'h0, rbase_q};
      default: cfg_rdata = '0;
    endcase
  end

  AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_hit && reg_hit)); // R8
  AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (win_idx == '0 && out_addr == {32'h0, addr})); // R4
  AST_NO_DISABLED_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> !dis_q[win_idx]); // R3
  AST_MASK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == K_DIS) |=> dis_q == $past(cfg_wdata[NUM_WIN-1:0])); // R9
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_chk
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (size_q[g] & (size_q[g] + 16'd1)) == 16'd0); // R5
  end

endmodule

// File: tb/addr_window_decoder_bench.sv
module addr_window_decoder_bench;
  localparam int NW = 8;
  localparam int RF = 4;
  localparam int IW = 3;

  logic          clk = 0, rst_n = 0, cfg_we = 0;
  logic [2:0]    cfg_kind = 0;
  logic [IW-1:0] cfg_idx = 0;
  logic [31:0]   cfg_wdata = 0, cfg_rdata, addr = 0;
  logic          win_hit, reg_hit;
  logic [IW-1:0] win_idx;
  logic [63:0]   out_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_base [NW], m_size [NW], m_rlo [NW];
  logic [31:0] m_rhi [NW];
  logic [NW-1:0] m_dis;
  logic [19:0] m_rbase;

  addr_window_decoder #(.NUM_WIN(NW), .REMAP_FIRST(RF), .REG_BASE_RST(20'h01400)) u_addr_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr(addr), .win_hit(win_hit),
    .win_idx(win_idx), .reg_hit(reg_hit), .out_addr(out_addr));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mdl_write(input logic [2:0] k, input int i, input logic [31:0] d);
    case (k)
      3'd0: m_base[i] = d[15:0];
      3'd1: if ((d[15:0] & (d[15:0] + 16'd1)) == 16'd0) m_size[i] = d[15:0];
      3'd2: m_rlo[i] = d[15:0];
      3'd3: m_rhi[i] = d;
      3'd4: m_dis = d[NW-1:0];
      3'd6: m_rbase = d[19:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [2:0] k, input int i, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_kind = k; cfg_idx = IW'(i); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    mdl_write(k, i, d);
  endtask

  task automatic rd(input string tag, input logic [2:0] k, input int i, input logic [31:0] exp);
    @(negedge clk);
    cfg_kind = k; cfg_idx = IW'(i);
    #1 chk(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic probe(input string tag, input logic [31:0] a);
    logic eh, er; logic [IW-1:0] ei; logic [63:0] eo;
    @(negedge clk);
    addr = a;
    #1;
    er = (a[31:16] == m_rbase[15:0]);
    eh = 0; ei = '0; eo = {32'h0, a};
    if (!er) begin
      for (int i = NW - 1; i >= 0; i--)
        if (!m_dis[i] && ((a[31:16] & ~m_size[i]) == (m_base[i] & ~m_size[i]))) begin
          eh = 1; ei = IW'(i);
        end
      if (eh && ei >= IW'(RF))
        eo = {m_rhi[ei], (m_base[ei] & ~m_size[ei]) | (m_rlo[ei] & m_size[ei]), a[15:0]};
    end
    chk({tag, " hit"}, 64'(win_hit), 64'(eh));
    chk({tag, " idx"}, 64'(win_idx), 64'(ei));
    chk({tag, " reg"}, 64'(reg_hit), 64'(er));
    chk({tag, " out"}, out_addr, eo);
  endtask

  task automatic t_reset;
    rd("R1 mask", 3'd4, 0, 32'hFF);
    rd("R1 size", 3'd1, 3, 32'h0);
    rd("R1 regbase", 3'd6, 0, 32'h01400);
    probe("R1 any-addr", 32'h0000_1234);
    probe("R1 R8 default reg", 32'h1400_0040);
  endtask

  task automatic t_basic;
    wr(3'd0, 0, 32'h1000);
    wr(3'd1, 0, 32'h00FF);
    wr(3'd4, 0, 32'hFE);
    probe("R2 inside", 32'h10AB_1234);
    probe("R2 top edge", 32'h10FF_FFFF);
    probe("R4 miss", 32'h1100_0000);
  endtask

  task automatic t_disabled;
    wr(3'd4, 0, 32'hFF);
    probe("R3 disabled", 32'h10AB_1234);
    chk("R3 no hit", 64'(win_hit), 64'h0);
  endtask

  task automatic t_priority;
    wr(3'd0, 1, 32'h1000);
    wr(3'd1, 1, 32'h0FFF);
    wr(3'd4, 0, 32'hFC);
    probe("R4 overlap low wins", 32'h1000_0010);
    chk("R4 idx0", 64'(win_idx), 64'h0);
    probe("R4 only win1", 32'h1800_0000);
    chk("R4 idx1", 64'(win_idx), 64'h1);
  endtask

  task automatic t_size;
    wr(3'd1, 1, 32'h00F0);
    rd("R5 illegal ignored", 3'd1, 1, 32'h0FFF);
    wr(3'd1, 2, 32'h0003);
    rd("R5 legal stored", 3'd1, 2, 32'h0003);
    rd("R6 eff enabled", 3'd5, 1, 32'h1000_0000);
    rd("R6 eff disabled", 3'd5, 2, 32'h0);
    wr(3'd1, 7, 32'hFFFF);
    wr(3'd4, 0, 32'h7C);
    rd("R6 eff wraps", 3'd5, 7, 32'h0);
    probe("R4 full win7 below", 32'hF000_0000);
    wr(3'd4, 0, 32'hFC);
  endtask

  task automatic t_next_clock;
    wr(3'd0, 2, 32'h3000);
    wr(3'd1, 2, 32'h0000);
    @(negedge clk);
    addr = 32'h3000_0004;
    cfg_we = 1; cfg_kind = 3'd4; cfg_wdata = 32'hF8;
    #1 chk("R9 before edge", 64'(win_hit), 64'h0);
    @(posedge clk); #1;
    chk("R9 after edge", 64'(win_hit), 64'h1);
    chk("R9 idx2", 64'(win_idx), 64'h2);
    @(negedge clk);
    cfg_we = 0;
    mdl_write(3'd4, 0, 32'hF8);
  endtask

  task automatic t_remap;
    wr(3'd0, 5, 32'h9000);
    wr(3'd1, 5, 32'h03FF);
    wr(3'd2, 5, 32'h1100);
    wr(3'd3, 5, 32'h0000_0002);
    wr(3'd4, 0, 32'hD8);
    rd("R9 remap lo", 3'd2, 5, 32'h1100);
    rd("R9 remap hi", 3'd3, 5, 32'h2);
    probe("R7 remap", 32'h9012_3456);
    chk("R7 value", out_addr, 64'h0000_0002_9100_3456);
    probe("R7 plain win", 32'h10AB_1234);
    chk("R7 plain value", out_addr, 64'h0000_0000_10AB_1234);
  endtask

  task automatic t_intreg;
    wr(3'd6, 0, 32'h000A_1000);
    rd("R8 readback", 3'd6, 0, 32'h000A_1000);
    probe("R8 over win0", 32'h1000_5678);
    chk("R8 reg_hit", 64'(reg_hit), 64'h1);
    probe("R8 neighbour", 32'h1001_0000);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_base[i] = 0; m_size[i] = 0; m_rlo[i] = 0; m_rhi[i] = 0;
    end
    m_dis = '1; m_rbase = 20'h01400;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_disabled;
    t_priority;
    t_size;
    t_next_clock;
    t_remap;
    t_intreg;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule